// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and a calendar in packed BCD. It counts seconds, minutes and hours in 24-hour form, a day of the week, the day of the month, the month and a two-digit year. A built-in prescaler divides a 32.768 kHz clock-enable strobe down to a one-cycle tick once per second. It also produces a 1 Hz square wave that is in phase with that tick.

A serial front end that sits beside the block uses three controls. It asserts `div_clr` to restart the prescaler. It raises `hold` so that no second is counted while a write is in progress. It pulses `load` to replace every field at once with the values on the load port. Carries ripple through all fields in the cycle of the tick. The length of each month, and February in leap years, are handled by the block itself.

Every field is packed BCD with the tens digit in bits [7:4] and the units digit in bits [3:0]. The weekday is a plain 3-bit binary count.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the outputs read 00:00:00, weekday 1, day 01, month 01, year 00, and `sq_1hz` is 1.
- R2: With `ref_en` held high, `tick_1hz` is high for exactly one cycle in every 2^PRESC_BITS enables, on the enable that wraps the prescaler. `sq_1hz` is high for the first half of each such period.
- R3: Seconds and minutes count 00 to 59 in BCD, with a units-digit carry from 9 to the tens digit. From 59 each wraps to 00 and advances the next field in the same cycle.
- R4: Hours count 00 to 23. From 23 they wrap to 00 and advance the day.
- R5: The day counts from 01 up to the month length and then wraps to 01, advancing the month. The length is 30 for months 04, 06, 09 and 11, 28 for month 02 in a non-leap year, and 31 for every other month.
- R6: A year whose BCD value is divisible by 4, including 00, is a leap year, and in it month 02 has 29 days.
- R7: The month counts 01 to 12. From 12 it wraps to 01 and advances the year, which counts 00 to 99 and wraps to 00.
- R8: The weekday counts 1 to 7 and then wraps to 1. It advances on the same tick as the day.
- R9: While `hold` is high, ticks are not counted and every field keeps its value. Counting resumes on the first tick after `hold` falls.
- R10: While `div_clr` is high the prescaler is held at zero and no tick is issued. The first tick after release comes on the 2^PRESC_BITS-th enable.
- R11: A `load` pulse replaces all seven fields with the load-port values on the next clock edge. It takes priority over a tick that arrives in the same cycle, so that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | 32.768 kHz clock-enable strobe |
| div_clr | input | 1 | Holds the prescaler at zero |
| hold | input | 1 | Blocks the seconds tick |
| load | input | 1 | Parallel load strobe |
| ld_sec | input | 8 | Seconds value to load (BCD) |
| ld_min | input | 8 | Minutes value to load (BCD) |
| ld_hr | input | 8 | Hours value to load (BCD) |
| ld_wday | input | 3 | Weekday value to load (1..7) |
| ld_day | input | 8 | Day value to load (BCD) |
| ld_mon | input | 8 | Month value to load (BCD) |
| ld_yr | input | 8 | Year value to load (BCD) |
| sec_o | output | 8 | Seconds (BCD) |
| min_o | output | 8 | Minutes (BCD) |
| hr_o | output | 8 | Hours (BCD) |
| wday_o | output | 3 | Weekday |
| day_o | output | 8 | Day of month (BCD) |
| mon_o | output | 8 | Month (BCD) |
| yr_o | output | 8 | Year (BCD) |
| tick_1hz | output | 1 | One-cycle pulse per second |
| sq_1hz | output | 1 | 1 Hz square wave aligned to the tick |

## Verification
The bench builds the block with PRESC_BITS set to 3, so one second takes eight enables instead of 32768. This lets each calendar rollover be reached in a few dozen cycles. The calendar logic does not depend on the prescaler width, so every month-end, leap-year, weekday and century wrap case is exercised at full fidelity. The shortened period also lets the bench count exact tick spacing, and observe the prescaler phase around `div_clr`, across several periods.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // True when a two-digit BCD year is a multiple of four (00 included).
  function automatic logic bcd_year_is_leap(input logic [7:0] yr);
    logic tens_odd;
    tens_odd = yr[4];
    if (!tens_odd) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else           return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  // Last valid day of a month, returned in BCD.
  function automatic logic [7:0] bcd_month_last_day(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] last;
    case (mon)
      8'h02:                      last = bcd_year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last = 8'h30;
      default:                    last = 8'h31;
    endcase
    return last;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic clr,
  output logic tick,
  output logic sq
);

  logic [DIV_BITS-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (ref_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = ref_en & ~clr & (&cnt_q);
  assign sq   = ~cnt_q[DIV_BITS-1];

  // R2: the tick never lasts more than one cycle
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R10: a clear leaves the divider at its start phase
  assert_clr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !tick);

endmodule

// File: rtl/bcd_pair_cnt.sv
module bcd_pair_cnt #(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       load,
  input  logic [7:0] ld_val,
  input  logic [7:0] lo_val,
  input  logic [7:0] hi_val,
  output logic [7:0] value,
  output logic       wrap
);

  logic [7:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    wrap  = 1'b0;
    if (load) begin
      val_d = ld_val;
    end else if (inc) begin
      if (val_q == hi_val) begin
        val_d = lo_val;
        wrap  = 1'b1;
      end else if (val_q[3:0] == 4'd9) begin
        val_d = {val_q[7:4] + 4'd1, 4'd0};
      end else begin
        val_d = {val_q[7:4], val_q[3:0] + 4'd1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= RST_VAL;
    else        val_q <= val_d;
  end

  assign value = val_q;

  // R3: an increment at the top of the range lands on the bottom value
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && val_q == hi_val) |=> (val_q == $past(lo_val)));

  // R9: with no increment and no load the field does not move
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(val_q));

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core #(
  parameter int PRESC_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       div_clr,
  input  logic       hold,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hr,
  input  logic [2:0] ld_wday,
  input  logic [7:0] ld_day,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_yr,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic [2:0] wday_o,
  output logic [7:0] day_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o,
  output logic       tick_1hz,
  output logic       sq_1hz
);
  import cal_pkg::*;

  localparam logic [2:0] WDAY_FIRST = 3'd1;
  localparam logic [2:0] WDAY_LAST  = 3'd7;

  logic sec_inc;
  logic sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap, yr_wrap;
  logic [7:0] day_last;
  logic [2:0] wday_q, wday_d;

  cal_prescaler #(.DIV_BITS(PRESC_BITS)) presc_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .clr(div_clr),
    .tick(tick_1hz), .sq(sq_1hz)
  );

  assign sec_inc  = tick_1hz & ~hold;
  assign day_last = bcd_month_last_day(mon_o, yr_o);

  bcd_pair_cnt #(.RST_VAL(8'h00)) sec_i (
    .clk(clk), .rst_n(rst_n), .inc(sec_inc), .load(load), .ld_val(ld_sec),
    .lo_val(8'h00), .hi_val(8'h59), .value(sec_o), .wrap(sec_wrap));

  bcd_pair_cnt #(.RST_VAL(8'h00)) min_i (
    .clk(clk), .rst_n(rst_n), .inc(sec_wrap), .load(load), .ld_val(ld_min),
    .lo_val(8'h00), .hi_val(8'h59), .value(min_o), .wrap(min_wrap));

  bcd_pair_cnt #(.RST_VAL(8'h00)) hr_i (
    .clk(clk), .rst_n(rst_n), .inc(min_wrap), .load(load), .ld_val(ld_hr),
    .lo_val(8'h00), .hi_val(8'h23), .value(hr_o), .wrap(hr_wrap));

  bcd_pair_cnt #(.RST_VAL(8'h01)) day_i (
    .clk(clk), .rst_n(rst_n), .inc(hr_wrap), .load(load), .ld_val(ld_day),
    .lo_val(8'h01), .hi_val(day_last), .value(day_o), .wrap(day_wrap));

  bcd_pair_cnt #(.RST_VAL(8'h01)) mon_i (
    .clk(clk), .rst_n(rst_n), .inc(day_wrap), .load(load), .ld_val(ld_mon),
    .lo_val(8'h01), .hi_val(8'h12), .value(mon_o), .wrap(mon_wrap));

  bcd_pair_cnt #(.RST_VAL(8'h00)) yr_i (
    .clk(clk), .rst_n(rst_n), .inc(mon_wrap), .load(load), .ld_val(ld_yr),
    .lo_val(8'h00), .hi_val(8'h99), .value(yr_o), .wrap(yr_wrap));

  // Weekday: advances together with the day of month
  always_comb begin
    wday_d = wday_q;
    if (load)         wday_d = ld_wday;
    else if (hr_wrap) wday_d = (wday_q == WDAY_LAST) ? WDAY_FIRST : wday_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wday_q <= WDAY_FIRST;
    else        wday_q <= wday_d;
  end

  assign wday_o = wday_q;

  // R11: a load replaces every field on the next edge
  assert_load_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec_o == $past(ld_sec) && min_o == $past(ld_min) && hr_o == $past(ld_hr) &&
              wday_o == $past(ld_wday) && day_o == $past(ld_day) &&
              mon_o == $past(ld_mon) && yr_o == $past(ld_yr)));

  // R9: hold freezes the whole calendar
  assert_hold_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> $stable({sec_o, min_o, hr_o, wday_o, day_o, mon_o, yr_o}));

  // R8: the weekday moves whenever the day moves
  assert_wday_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hr_wrap |=> (wday_o != $past(wday_o)));

  // R5: leaving the last day of a month lands on day 01
  assert_month_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    day_wrap |=> (day_o == 8'h01));

  // R6: February 28 of a leap year is followed by February 29
  assert_leap_feb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_wrap && !load && mon_o == 8'h02 && day_o == 8'h28 && bcd_year_is_leap(yr_o))
      |=> (day_o == 8'h29 && mon_o == 8'h02));

  // R7: the year only changes on a month wrap or a load
  assert_year_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_wrap && !load) |=> $stable(yr_o));

endmodule

// File: tb/bcd_calendar_core_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_core_tb_top;

  localparam int PB = 3;
  localparam int PERIOD_EN = 1 << PB;

  typedef struct packed {
    logic [7:0] sec; logic [7:0] min; logic [7:0] hr; logic [2:0] wday;
    logic [7:0] day; logic [7:0] mon; logic [7:0] yr;
  } cal_t;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_en, div_clr, hold, load;
  logic [7:0] ld_sec, ld_min, ld_hr, ld_day, ld_mon, ld_yr;
  logic [2:0] ld_wday;
  logic [7:0] sec_o, min_o, hr_o, day_o, mon_o, yr_o;
  logic [2:0] wday_o;
  logic tick_1hz, sq_1hz;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  cal_t  exp_q[$];
  string tag_q[$];
  event  cmp_ev;

  always #2 clk = ~clk;

  bcd_calendar_core #(.PRESC_BITS(PB)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .div_clr(div_clr), .hold(hold), .load(load),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hr(ld_hr), .ld_wday(ld_wday),
    .ld_day(ld_day), .ld_mon(ld_mon), .ld_yr(ld_yr),
    .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .wday_o(wday_o),
    .day_o(day_o), .mon_o(mon_o), .yr_o(yr_o),
    .tick_1hz(tick_1hz), .sq_1hz(sq_1hz));

  function automatic cal_t mk(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                              input logic [2:0] w, input logic [7:0] d, input logic [7:0] mo,
                              input logic [7:0] y);
    cal_t c;
    c.sec = s; c.min = m; c.hr = h; c.wday = w; c.day = d; c.mon = mo; c.yr = y;
    return c;
  endfunction

  function automatic cal_t now();
    return mk(hr_o, min_o, sec_o, wday_o, day_o, mon_o, yr_o);
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected calendars and compares with the outputs
  initial begin
    forever begin
      @(cmp_ev);
      while (exp_q.size() > 0) begin
        cal_t  e;
        cal_t  a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = now();
        n_checks++;
        if (a !== e) begin
          n_errors++;
          $display("FAIL %s: actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  task automatic expect_cal(input string tag, input cal_t e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    ->cmp_ev;
    #0;
  endtask

  // Loads a calendar and restarts the prescaler in the same cycle
  task automatic load_cal(input cal_t c);
    ld_sec = c.sec; ld_min = c.min; ld_hr = c.hr; ld_wday = c.wday;
    ld_day = c.day; ld_mon = c.mon; ld_yr = c.yr;
    load = 1'b1; div_clr = 1'b1;
    @(posedge clk); #1;
    load = 1'b0; div_clr = 1'b0;
  endtask

  task automatic enables(input int n);
    ref_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
    ref_en = 1'b0;
  endtask

  task automatic step_case(input string tag, input cal_t from, input cal_t to);
    load_cal(from);
    enables(PERIOD_EN);
    expect_cal(tag, to);
  endtask

  initial begin
    rst_n = 1'b0; ref_en = 1'b0; div_clr = 1'b0; hold = 1'b0; load = 1'b0;
    ld_sec = '0; ld_min = '0; ld_hr = '0; ld_wday = '0; ld_day = '0; ld_mon = '0; ld_yr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    expect_cal("R1 reset calendar", mk(8'h00, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h00));
    check_bit("R1 reset sq_1hz", sq_1hz, 1'b1);
    check_bit("R1 reset tick", tick_1hz, 1'b0);

    // R2: tick spacing and square-wave phase over two periods
    begin
      int ticks = 0;
      int sq_hi = 0;
      int tick_at = -1;
      load_cal(mk(8'h00, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h00));
      ref_en = 1'b1;
      for (int j = 0; j < 2 * PERIOD_EN; j++) begin
        if (tick_1hz) begin ticks++; if (tick_at < 0) tick_at = j; end
        if (sq_1hz) sq_hi++;
        @(posedge clk); #1;
      end
      ref_en = 1'b0;
      check_int("R2 tick count", ticks, 2);
      check_int("R2 first tick enable index", tick_at, PERIOD_EN - 1);
      check_int("R2 square wave high cycles", sq_hi, PERIOD_EN);
    end

    // R3: second counting and minute carry
    step_case("R3 seconds 57->58", mk(8'h12, 8'h34, 8'h57, 3'd2, 8'h10, 8'h05, 8'h21),
                                   mk(8'h12, 8'h34, 8'h58, 3'd2, 8'h10, 8'h05, 8'h21));
    step_case("R3 units carry 09->10", mk(8'h12, 8'h34, 8'h09, 3'd2, 8'h10, 8'h05, 8'h21),
                                       mk(8'h12, 8'h34, 8'h10, 3'd2, 8'h10, 8'h05, 8'h21));
    step_case("R3 minute carry", mk(8'h12, 8'h09, 8'h59, 3'd2, 8'h10, 8'h05, 8'h21),
                                 mk(8'h12, 8'h10, 8'h00, 3'd2, 8'h10, 8'h05, 8'h21));
    // R4: midnight
    step_case("R4 midnight 23:59:59", mk(8'h23, 8'h59, 8'h59, 3'd3, 8'h15, 8'h06, 8'h24),
                                      mk(8'h00, 8'h00, 8'h00, 3'd4, 8'h16, 8'h06, 8'h24));
    step_case("R4 hour carry 09:59:59", mk(8'h09, 8'h59, 8'h59, 3'd3, 8'h15, 8'h06, 8'h24),
                                        mk(8'h10, 8'h00, 8'h00, 3'd3, 8'h15, 8'h06, 8'h24));
    // R5: month lengths
    step_case("R5 non-leap Feb 28", mk(8'h23, 8'h59, 8'h59, 3'd2, 8'h28, 8'h02, 8'h23),
                                    mk(8'h00, 8'h00, 8'h00, 3'd3, 8'h01, 8'h03, 8'h23));
    step_case("R5 Apr 30", mk(8'h23, 8'h59, 8'h59, 3'd5, 8'h30, 8'h04, 8'h23),
                           mk(8'h00, 8'h00, 8'h00, 3'd6, 8'h01, 8'h05, 8'h23));
    step_case("R5 Jan 30 to 31", mk(8'h23, 8'h59, 8'h59, 3'd5, 8'h30, 8'h01, 8'h23),
                                 mk(8'h00, 8'h00, 8'h00, 3'd6, 8'h31, 8'h01, 8'h23));
    step_case("R5 Nov 30", mk(8'h23, 8'h59, 8'h59, 3'd4, 8'h30, 8'h11, 8'h23),
                           mk(8'h00, 8'h00, 8'h00, 3'd5, 8'h01, 8'h12, 8'h23));
    // R6: leap years
    step_case("R6 leap Feb 28 (24)", mk(8'h23, 8'h59, 8'h59, 3'd3, 8'h28, 8'h02, 8'h24),
                                     mk(8'h00, 8'h00, 8'h00, 3'd4, 8'h29, 8'h02, 8'h24));
    step_case("R6 leap Feb 29 (24)", mk(8'h23, 8'h59, 8'h59, 3'd4, 8'h29, 8'h02, 8'h24),
                                     mk(8'h00, 8'h00, 8'h00, 3'd5, 8'h01, 8'h03, 8'h24));
    step_case("R6 leap Feb 28 (00)", mk(8'h23, 8'h59, 8'h59, 3'd1, 8'h28, 8'h02, 8'h00),
                                     mk(8'h00, 8'h00, 8'h00, 3'd2, 8'h29, 8'h02, 8'h00));
    step_case("R6 leap Feb 28 (92)", mk(8'h23, 8'h59, 8'h59, 3'd1, 8'h28, 8'h02, 8'h92),
                                     mk(8'h00, 8'h00, 8'h00, 3'd2, 8'h29, 8'h02, 8'h92));
    // R7 and R8: year end and weekday wrap
    step_case("R7 R8 Dec 31 99", mk(8'h23, 8'h59, 8'h59, 3'd7, 8'h31, 8'h12, 8'h99),
                                 mk(8'h00, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h00));
    step_case("R7 Dec 31 23", mk(8'h23, 8'h59, 8'h59, 3'd6, 8'h31, 8'h12, 8'h23),
                              mk(8'h00, 8'h00, 8'h00, 3'd7, 8'h01, 8'h01, 8'h24));

    // R9: hold blocks the tick, release resumes counting
    load_cal(mk(8'h08, 8'h15, 8'h30, 3'd2, 8'h10, 8'h05, 8'h21));
    hold = 1'b1;
    enables(PERIOD_EN);
    expect_cal("R9 held through a tick", mk(8'h08, 8'h15, 8'h30, 3'd2, 8'h10, 8'h05, 8'h21));
    hold = 1'b0;
    enables(PERIOD_EN);
    expect_cal("R9 resumes after release", mk(8'h08, 8'h15, 8'h31, 3'd2, 8'h10, 8'h05, 8'h21));

    // R10: divider clear delays the next tick
    load_cal(mk(8'h10, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h22));
    enables(PERIOD_EN - 3);
    div_clr = 1'b1;
    enables(3);
    div_clr = 1'b0;
    expect_cal("R10 no tick while cleared", mk(8'h10, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h22));
    enables(PERIOD_EN - 1);
    expect_cal("R10 no tick before full period", mk(8'h10, 8'h00, 8'h00, 3'd1, 8'h01, 8'h01, 8'h22));
    enables(1);
    expect_cal("R10 tick after full period", mk(8'h10, 8'h00, 8'h01, 3'd1, 8'h01, 8'h01, 8'h22));

    // R11: load wins over a coincident tick
    load_cal(mk(8'h01, 8'h02, 8'h03, 3'd4, 8'h05, 8'h06, 8'h07));
    enables(PERIOD_EN - 1);
    ld_sec = 8'h45; ld_min = 8'h44; ld_hr = 8'h17; ld_wday = 3'd6;
    ld_day = 8'h19; ld_mon = 8'h08; ld_yr = 8'h55;
    load = 1'b1; ref_en = 1'b1;
    @(posedge clk); #1;
    load = 1'b0; ref_en = 1'b0;
    expect_cal("R11 load over tick", mk(8'h17, 8'h44, 8'h45, 3'd6, 8'h19, 8'h08, 8'h55));

    #1;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule